// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block walks a ring of transmit buffer descriptors held in a small on-chip RAM and hands each filled descriptor to a downstream data mover. A descriptor carries a full flag (the buffer holds data ready to send) and a last flag (the buffer closes a frame). For every full descriptor the sequencer raises a one-cycle transfer request naming the descriptor address. The transmit path answers either that the buffer was consumed and the frame continues, or that the frame ended, together with the MAC completion status and a success flag.

At frame end the status is written into the descriptor the sequencer is standing on. A successful frame raises the done interrupt bit and the walk continues with the next address. A failed or aborted frame raises the error interrupt bit, captures the failing descriptor address in a read-only error pointer and stops. Reaching an empty descriptor raises the idle interrupt bit and stops. Once stopped, the sequencer waits for software to drive the clear bit of the control register from 0 to 1, and it then restarts at the address software placed in the recover pointer. Reset leaves it stopped, so the first frame also needs such a toggle.

States: HALT (stopped), FETCH (descriptor read issued), CHECK (read data inspected), SEND (transfer request), WAIT (awaiting the transmit path), WBACK (status write-back). Transitions: HALT to FETCH on a clear-bit rising edge, loading the recover pointer; FETCH to CHECK always; CHECK to SEND when the full flag is set, CHECK to HALT (idle) when it is clear; SEND to WAIT always; WAIT to WBACK on frame end; WAIT to FETCH on buffer consumed at a non-last descriptor, with the address incremented; WBACK to FETCH after success with the address incremented, WBACK to HALT after an error.

Top module: `txd_ring_seq`

## Requirements
- R1: After reset the sequencer is in HALT, every register reads 0, `irq_stat` is 0, and no descriptor read or transfer happens until a clear-bit rising edge.
- R2: A 0-to-1 change of control bit 0 (offset 0) while halted restarts the walk at the recover pointer (offset 1, bits AW-1:0); writing 1 again while it is already 1 starts nothing.
- R3: A descriptor word has its full flag at bit DW-1 and its last flag at bit DW-2; a full descriptor yields one `xfer_req` pulse carrying its address and last flag, descriptors are taken in increasing address order, and the address wraps from 2^AW-1 to 0.
- R4: A descriptor whose full flag is 0 sets the idle bit (bit 1 of `irq_stat`) and halts.
- R5: A frame end with `resp_ok` high at a last descriptor writes `resp_stat` into that descriptor, sets the done bit (bit 0), and fetches the next address.
- R6: A frame end with `resp_ok` low writes `resp_stat` into the current descriptor, sets the error bit (bit 2), loads its address into the error pointer (offset 3), and halts.
- R7: A frame end at a descriptor whose last flag is 0 (aborted frame) writes the status into that non-last descriptor and is handled as an error as in R6.
- R8: A buffer-consumed response at a non-last descriptor advances to the next address without any status write.
- R9: The interrupt bits (offset 2) are sticky and cleared by writing 1s; a set and a clear of the same bit in one cycle leaves it set.
- R10: The error pointer is read-only and keeps its value until the next error.
- R11: In any cycle at most one of descriptor read, status write and transfer request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register offset (0 control, 1 recover pointer, 2 interrupt status, 3 error pointer) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| ram_rd_en | output | 1 | Descriptor read enable; data returns one cycle later |
| ram_rd_addr | output | AW | Descriptor read address |
| ram_rd_data | input | DW | Descriptor word read from the RAM |
| ram_wr_en | output | 1 | Status write-back enable |
| ram_wr_addr | output | AW | Status write-back address |
| ram_wr_stat | output | STW | Status value written into the descriptor |
| xfer_req | output | 1 | One-cycle request to move the buffer of a descriptor |
| xfer_addr | output | AW | Descriptor address of the request |
| xfer_last | output | 1 | The requested descriptor closes its frame |
| resp_next | input | 1 | Buffer consumed, frame continues |
| resp_done | input | 1 | Frame ended; status valid |
| resp_ok | input | 1 | Frame ended without error |
| resp_stat | input | STW | MAC completion status |
| irq_stat | output | 3 | Sticky interrupt bits: 0 done, 1 idle, 2 error |

## Verification
Directed runs exercise a chain of single-buffer frames ending on an empty descriptor, a two-buffer frame, a failed frame, a frame aborted on a non-last buffer and a walk across the address wrap, which separate the success, idle, error and abort paths and the order of addresses. Random rings with a random start, length, last flags and responses are compared against a bench model of the walk, covering the list of transfer addresses, the status write-backs, the interrupt bits and the error pointer. Corner cases cover a repeated write of 1 to the clear bit, a write-one-to-clear landing in the same cycle as a set, and silence before the first toggle.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int CSR_W = 32;
    localparam int IRQ_W = 3;

    localparam int IRQ_DONE = 0;
    localparam int IRQ_IDLE = 1;
    localparam int IRQ_ERR  = 2;

    localparam logic [1:0] REG_CTL = 2'd0;
    localparam logic [1:0] REG_RCV = 2'd1;
    localparam logic [1:0] REG_IRQ = 2'd2;
    localparam logic [1:0] REG_ERR = 2'd3;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_FETCH,
        ST_CHECK,
        ST_SEND,
        ST_WAIT,
        ST_WBACK
    } seq_state_t;

    // bit order matches irq_stat: done in bit 0
    typedef struct packed {
        logic err;
        logic idle;
        logic done;
    } irq_set_t;

endpackage

// File: rtl/txd_edge.sv
module txd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/txd_csr.sv
module txd_csr
    import txd_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [1:0]       csr_addr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  irq_set_t         sets,
    input  logic             err_ld,
    input  logic [AW-1:0]    err_addr,
    output logic             ctl_clr,
    output logic [AW-1:0]    rcv_ptr,
    output logic [IRQ_W-1:0] irq_stat
);

    logic [AW-1:0]    err_ptr;
    logic [IRQ_W-1:0] w1c;
    logic [IRQ_W-1:0] set_vec;
    logic             unused_wdata;

    assign unused_wdata = ^csr_wdata[CSR_W-1:AW];
    assign set_vec      = sets;
    assign w1c          = (csr_wr && csr_addr == REG_IRQ) ? csr_wdata[IRQ_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_clr  <= 1'b0;
            rcv_ptr  <= '0;
            irq_stat <= '0;
            err_ptr  <= '0;
        end else begin
            if (csr_wr && csr_addr == REG_CTL) ctl_clr <= csr_wdata[0];
            if (csr_wr && csr_addr == REG_RCV) rcv_ptr <= csr_wdata[AW-1:0];
            // set wins over a clear in the same cycle
            irq_stat <= (irq_stat & ~w1c) | set_vec;
            if (err_ld) err_ptr <= err_addr;
        end
    end

    always_comb begin
        csr_rdata = '0;
        unique case (csr_addr)
            REG_CTL: csr_rdata = CSR_W'(ctl_clr);
            REG_RCV: csr_rdata = CSR_W'(rcv_ptr);
            REG_IRQ: csr_rdata = CSR_W'(irq_stat);
            REG_ERR: csr_rdata = CSR_W'(err_ptr);
            default: csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txd_fsm.sv
module txd_fsm
    import txd_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int STW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_rise,
    input  logic [AW-1:0]  rcv_ptr,
    input  logic [DW-1:0]  rd_data,
    input  logic           resp_next,
    input  logic           resp_done,
    input  logic           resp_ok,
    input  logic [STW-1:0] resp_stat,
    output logic           rd_en,
    output logic           wr_en,
    output logic           xfer_req,
    output logic           xfer_last,
    output logic [AW-1:0]  cur_addr,
    output logic [STW-1:0] wr_stat,
    output irq_set_t       sets,
    output logic           err_ld
);

    localparam int F_BIT = DW - 1;
    localparam int L_BIT = DW - 2;

    seq_state_t     state, nxt;
    logic [AW-1:0]  ptr;
    logic           cur_last;
    logic [STW-1:0] stat_q;
    logic           err_q;
    logic           desc_full;
    logic           desc_last;
    logic           unused_desc;

    assign desc_full   = rd_data[F_BIT];
    assign desc_last   = rd_data[L_BIT];
    assign unused_desc = ^rd_data[L_BIT-1:0];

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HALT:  if (clr_rise) nxt = ST_FETCH;
            ST_FETCH: nxt = ST_CHECK;
            ST_CHECK: nxt = desc_full ? ST_SEND : ST_HALT;
            ST_SEND:  nxt = ST_WAIT;
            ST_WAIT: begin
                if (resp_done)                  nxt = ST_WBACK;
                else if (resp_next && !cur_last) nxt = ST_FETCH;
            end
            ST_WBACK: nxt = err_q ? ST_HALT : ST_FETCH;
            default:  nxt = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            cur_last <= 1'b0;
            stat_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_HALT:  if (clr_rise) ptr <= rcv_ptr;
                ST_CHECK: if (desc_full) cur_last <= desc_last;
                ST_WAIT: begin
                    if (resp_done) begin
                        stat_q <= resp_stat;
                        err_q  <= !resp_ok || !cur_last;
                    end else if (resp_next && !cur_last) begin
                        ptr <= ptr + AW'(1);
                    end
                end
                ST_WBACK: if (!err_q) ptr <= ptr + AW'(1);
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_en     = (state == ST_FETCH);
        xfer_req  = (state == ST_SEND);
        wr_en     = (state == ST_WBACK);
        xfer_last = cur_last;
        cur_addr  = ptr;
        wr_stat   = stat_q;
        sets.idle = (state == ST_CHECK) && !desc_full;
        sets.done = (state == ST_WBACK) && !err_q;
        sets.err  = (state == ST_WBACK) && err_q;
        err_ld    = (state == ST_WBACK) && err_q;
    end

endmodule

// File: rtl/txd_ring_seq.sv
module txd_ring_seq
    import txd_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int STW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [1:0]       csr_addr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    output logic             ram_rd_en,
    output logic [AW-1:0]    ram_rd_addr,
    input  logic [DW-1:0]    ram_rd_data,
    output logic             ram_wr_en,
    output logic [AW-1:0]    ram_wr_addr,
    output logic [STW-1:0]   ram_wr_stat,
    output logic             xfer_req,
    output logic [AW-1:0]    xfer_addr,
    output logic             xfer_last,
    input  logic             resp_next,
    input  logic             resp_done,
    input  logic             resp_ok,
    input  logic [STW-1:0]   resp_stat,
    output logic [IRQ_W-1:0] irq_stat
);

    logic          ctl_clr;
    logic          clr_rise;
    logic [AW-1:0] rcv_ptr;
    logic [AW-1:0] cur_addr;
    irq_set_t      sets;
    logic          err_ld;

    txd_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (ctl_clr),
        .rise (clr_rise)
    );

    txd_csr #(.AW(AW)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_wr   (csr_wr),
        .csr_addr (csr_addr),
        .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .sets     (sets),
        .err_ld   (err_ld),
        .err_addr (cur_addr),
        .ctl_clr  (ctl_clr),
        .rcv_ptr  (rcv_ptr),
        .irq_stat (irq_stat)
    );

    txd_fsm #(.AW(AW), .DW(DW), .STW(STW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_rise (clr_rise),
        .rcv_ptr  (rcv_ptr),
        .rd_data  (ram_rd_data),
        .resp_next(resp_next),
        .resp_done(resp_done),
        .resp_ok  (resp_ok),
        .resp_stat(resp_stat),
        .rd_en    (ram_rd_en),
        .wr_en    (ram_wr_en),
        .xfer_req (xfer_req),
        .xfer_last(xfer_last),
        .cur_addr (cur_addr),
        .wr_stat  (ram_wr_stat),
        .sets     (sets),
        .err_ld   (err_ld)
    );

    assign ram_rd_addr = cur_addr;
    assign ram_wr_addr = cur_addr;
    assign xfer_addr   = cur_addr;

endmodule

// File: rtl/txd_ring_seq_chk.sv
module txd_ring_seq_chk
    import txd_pkg::*;
#(
    parameter int AW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ram_rd_en,
    input logic             ram_wr_en,
    input logic             xfer_req,
    input logic             resp_done,
    input logic             desc_full,
    input logic [AW-1:0]    ram_rd_addr,
    input logic [AW-1:0]    xfer_addr,
    input logic [IRQ_W-1:0] irq_stat
);

    // R11
    one_ram_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_rd_en, ram_wr_en, xfer_req}));

    // R3
    xfer_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> $past(ram_rd_en, 2) && $past(desc_full) && (xfer_addr == $past(ram_rd_addr, 2)));

    // R4
    idle_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat[IRQ_IDLE]) |-> $past(ram_rd_en, 2) && !$past(desc_full));

    // R5
    done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat[IRQ_DONE]) |-> $past(ram_wr_en));

    // R6
    err_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat[IRQ_ERR]) |-> $past(ram_wr_en));

    // R5
    wb_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> $past(resp_done));

endmodule

bind txd_ring_seq txd_ring_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ram_rd_en  (ram_rd_en),
    .ram_wr_en  (ram_wr_en),
    .xfer_req   (xfer_req),
    .resp_done  (resp_done),
    .desc_full  (ram_rd_data[DW-1]),
    .ram_rd_addr(ram_rd_addr),
    .xfer_addr  (xfer_addr),
    .irq_stat   (irq_stat)
);

// File: tb/test_txd_ring_seq.sv
`timescale 1ns/1ps
module test_txd_ring_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        ram_rd_en;
    logic [7:0]  ram_rd_addr;
    logic [31:0] ram_rd_data = '0;
    logic        ram_wr_en;
    logic [7:0]  ram_wr_addr;
    logic [15:0] ram_wr_stat;
    logic        xfer_req;
    logic [7:0]  xfer_addr;
    logic        xfer_last;
    logic        resp_next = 1'b0;
    logic        resp_done = 1'b0;
    logic        resp_ok = 1'b0;
    logic [15:0] resp_stat = '0;
    logic [2:0]  irq_stat;

    always #2.5 clk = ~clk;

    txd_ring_seq i_txd_ring_seq (.*);

    // descriptor memory and response plan; 0 next, 1 end ok, 2 end fail
    logic [31:0] mem [256];
    int          plan_code [256];
    logic [15:0] plan_stat [256];

    int nchk = 0;
    int nerr = 0;

    // logs owned by the monitors
    int         xcnt = 0;
    logic [7:0] xlog_a [1024];
    logic       xlog_l [1024];
    int         wcnt = 0;
    logic [7:0] wlog_a [1024];
    logic [15:0] wlog_s [1024];

    // expected results of one walk
    int          exp_xn, exp_wn;
    logic [7:0]  exp_xa [64];
    logic        exp_xl [64];
    logic [7:0]  exp_wa [64];
    logic [15:0] exp_ws [64];
    logic [2:0]  exp_irq;
    logic [7:0]  exp_errptr = '0;

    always @(posedge clk) if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];

    always @(negedge clk) begin
        if (rst_n && ram_wr_en) begin
            wlog_a[wcnt] = ram_wr_addr;
            wlog_s[wcnt] = ram_wr_stat;
            wcnt = wcnt + 1;
        end
    end

    initial begin : responder
        logic [7:0] a;
        forever begin
            @(negedge clk);
            if (rst_n && xfer_req) begin
                a = xfer_addr;
                xlog_a[xcnt] = a;
                xlog_l[xcnt] = xfer_last;
                xcnt = xcnt + 1;
                repeat (1 + int'(a) % 3) @(negedge clk);
                resp_stat = plan_stat[a];
                if (plan_code[a] == 0) resp_next = 1'b1;
                else begin
                    resp_done = 1'b1;
                    resp_ok   = (plan_code[a] == 1);
                end
                @(negedge clk);
                resp_next = 1'b0;
                resp_done = 1'b0;
                resp_ok   = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nerr = nerr + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
        @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            plan_code[i] = 1;
            plan_stat[i] = 16'h0;
        end
    endtask

    task automatic set_desc(input logic [7:0] a, input logic f, input logic l, input int code);
        mem[a] = {f, l, 14'h0, 8'h3C, a};
        plan_code[a] = code;
        plan_stat[a] = {8'hA0 ^ a, ~a};
    endtask

    // bench model of the walk from a start address
    function automatic void model(input logic [7:0] start);
        logic [7:0] a;
        logic lst;
        a = start; exp_xn = 0; exp_wn = 0; exp_irq = 3'b000;
        for (int k = 0; k < 64; k++) begin
            if (!mem[a][31]) begin exp_irq[1] = 1'b1; break; end
            lst = mem[a][30];
            exp_xa[exp_xn] = a; exp_xl[exp_xn] = lst; exp_xn++;
            if (plan_code[a] == 0 && !lst) begin a = a + 8'd1; continue; end
            exp_wa[exp_wn] = a; exp_ws[exp_wn] = plan_stat[a]; exp_wn++;
            if (plan_code[a] == 2 || !lst) begin
                exp_irq[2] = 1'b1; exp_errptr = a; break;
            end
            exp_irq[0] = 1'b1;
            a = a + 8'd1;
        end
    endfunction

    task automatic kick(input logic [7:0] start);
        csr_write(2'd2, 32'h7);
        csr_write(2'd1, {24'h0, start});
        csr_write(2'd0, 32'h0);
        csr_write(2'd0, 32'h1);
    endtask

    task automatic compare(input int xb, input int wb, input string tag);
        logic [31:0] d;
        check({"R3 transfer count ", tag}, xcnt - xb, exp_xn);
        for (int i = 0; i < exp_xn && i < xcnt - xb; i++) begin
            check({"R3 transfer address ", tag}, xlog_a[xb + i], exp_xa[i]);
            check({"R3 transfer last flag ", tag}, xlog_l[xb + i], exp_xl[i]);
        end
        check({"R5 R7 R8 status write count ", tag}, wcnt - wb, exp_wn);
        for (int i = 0; i < exp_wn && i < wcnt - wb; i++) begin
            check({"R5 R7 status write address ", tag}, wlog_a[wb + i], exp_wa[i]);
            check({"R5 R6 status write value ", tag}, wlog_s[wb + i], exp_ws[i]);
        end
        csr_read(2'd2, d);
        check({"R4 R5 R6 interrupt bits ", tag}, d, {29'h0, exp_irq});
        check({"R4 R5 R6 irq_stat port ", tag}, irq_stat, exp_irq);
        csr_read(2'd3, d);
        check({"R6 R10 error pointer ", tag}, d, {24'h0, exp_errptr});
    endtask

    task automatic episode(input logic [7:0] start, input string tag);
        int xb, wb;
        xb = xcnt; wb = wcnt;
        kick(start);
        repeat (200) @(negedge clk);
        model(start);
        compare(xb, wb, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nerr = nerr + 1;
        nchk = nchk + 1;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int          rd_seen;
        int          xb;
        logic [7:0]  st;
        int          n;
        logic        l;
        void'($urandom(32'd4242));
        clear_mem();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int r = 0; r < 4; r++) begin
            csr_read(r[1:0], d);
            check("R1 register after reset", d, 32'h0);
        end
        check("R1 irq_stat after reset", irq_stat, 3'b000);
        set_desc(8'd0, 1'b1, 1'b1, 1);
        rd_seen = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (ram_rd_en) rd_seen++;
        end
        check("R1 no fetch before first toggle", rd_seen, 0);
        check("R1 no transfer before first toggle", xcnt, 0);

        // chain of single-buffer frames ending on an empty descriptor
        clear_mem();
        set_desc(8'd10, 1'b1, 1'b1, 1);
        set_desc(8'd11, 1'b1, 1'b1, 1);
        set_desc(8'd12, 1'b1, 1'b1, 1);
        episode(8'd10, "chain R2");

        // R2: writing 1 again while the bit is 1 starts nothing
        xb = xcnt;
        csr_write(2'd1, 32'd10);
        csr_write(2'd0, 32'h1);
        repeat (80) @(negedge clk);
        check("R2 level held high does not restart", xcnt - xb, 0);

        // R8 two-buffer frame
        clear_mem();
        set_desc(8'd20, 1'b1, 1'b0, 0);
        set_desc(8'd21, 1'b1, 1'b1, 1);
        episode(8'd20, "two-buffer R8");

        // R6 failed frame
        clear_mem();
        set_desc(8'd50, 1'b1, 1'b1, 2);
        set_desc(8'd51, 1'b1, 1'b1, 1);
        episode(8'd50, "failed frame R6");

        // R7 frame ended on a non-last buffer
        clear_mem();
        set_desc(8'd60, 1'b1, 1'b0, 1);
        set_desc(8'd61, 1'b1, 1'b1, 1);
        episode(8'd60, "aborted frame R7");

        // R3 wrap from 255 to 0
        clear_mem();
        set_desc(8'd254, 1'b1, 1'b0, 0);
        set_desc(8'd255, 1'b1, 1'b1, 1);
        set_desc(8'd0,   1'b1, 1'b1, 1);
        episode(8'd254, "wrap R3");

        // R9 clear landing in the cycle that sets the done bit
        clear_mem();
        set_desc(8'd40, 1'b1, 1'b1, 1);
        kick(8'd40);
        for (int c = 0; c < 100 && !ram_wr_en; c++) @(negedge clk);
        csr_write(2'd2, 32'h1);
        repeat (40) @(negedge clk);
        csr_read(2'd2, d);
        check("R9 set wins over same-cycle clear", d, 32'h3);
        csr_write(2'd2, 32'h1);
        csr_read(2'd2, d);
        check("R9 write one clears only that bit", d, 32'h2);
        csr_write(2'd2, 32'h7);
        csr_read(2'd2, d);
        check("R9 all bits cleared", d, 32'h0);
        csr_read(2'd3, d);
        check("R10 error pointer kept after success", d, {24'h0, exp_errptr});

        // random rings
        for (int e = 0; e < 25; e++) begin
            clear_mem();
            st = 8'($urandom % 256);
            n = 1 + int'($urandom % 6);
            for (int i = 0; i < n; i++) begin
                l = 1'($urandom % 2);
                if (l) set_desc(st + 8'(i), 1'b1, 1'b1, ($urandom % 5 == 0) ? 2 : 1);
                else   set_desc(st + 8'(i), 1'b1, 1'b0, ($urandom % 6 == 0) ? int'(1 + $urandom % 2) : 0);
                plan_stat[st + 8'(i)] = 16'($urandom);
            end
            episode(st, "random");
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule